// File: doc/BRIEF.md
# Tile Health Supervisor

This block watches a processor array built from identical tiles that run replicated threads. Each tile reports, per checkpoint, whether its result disagreed with its siblings. Each tile also strobes a checkpoint pulse that a per-tile watchdog monitors. While every tile agrees and strobes on time, the supervisor does nothing. When a tile misbehaves, the supervisor increments that tile's fault count and escalates in steps. The first step is a state resync of the tile. The next is replacing it with a spare and repairing it. The last is retiring the tile for good. If the array runs out of spares, a degraded flag is raised.

Repair of a tile is one sequence of handshakes with external agents. It tries each partial reconfiguration variant in turn and then one full reconfiguration. Every reconfiguration is followed by a self-test, during which the tile is released from reset. A tile that passes becomes a spare. A tile for which every attempt fails is retired. Only one repair runs at a time. Faults that arrive meanwhile wait in a pending vector and are served in order of tile index.

Each tile has a health state: H_ACTIVE, H_SPARE, H_REPAIR or H_RETIRED. The controller has five phases:
- S_IDLE: serves the pending fault with the lowest index, one per cycle.
- S_REQ: issues a one-cycle reconfiguration request.
- S_RWAIT: waits for the reconfiguration result.
- S_TEST: issues a one-cycle self-test request.
- S_TWAIT: waits for the self-test result.

The transitions are:
- S_IDLE to S_REQ on a swap.
- S_REQ to S_RWAIT always.
- S_RWAIT to S_TEST when the reconfiguration completes without failure.
- S_RWAIT or S_TWAIT back to S_REQ on a failed attempt while attempts remain.
- S_RWAIT or S_TWAIT to S_IDLE on a failed last attempt (the tile retires).
- S_TWAIT to S_IDLE on a self-test pass (the tile becomes a spare).

Top module: `tile_health_supervisor`

## Requirements
- R1: After reset, tiles 0 to N_TILES-N_SPARE-1 are active and the rest are spare. Every request output, isolate, reset and degraded is low.
- R2: With no disagreement and all active tiles strobing, all command outputs stay low.
- R3: A fault whose new count is below SWAP_AT gives a one-cycle resync_req on that tile only. It appears in the cycle after the edge that samples the fault.
- R4: When several faults are pending, the lowest tile index is served first, one per cycle. Faults that arrive during a repair are held and served after the repair ends.
- R5: When a fault brings a count to between SWAP_AT and RETIRE_LIMIT and a spare exists, three things happen on the same edge. The lowest-index spare gets a one-cycle spare_act. The faulty tile is isolated and held in reset. part_reconf_req is raised with cfg_variant 0.
- R6: Each repair attempt is one of the following, in order: partial variants 0 to N_VARIANTS-1 via part_reconf_req, then a full reconfiguration via full_reconf_req. A completed reconfiguration is followed by a one-cycle selftest_req, during which tile_reset is low and tile_isolate stays high. A self-test pass returns the tile to spare, which drops its isolation.
- R7: Any of three events fails the current attempt and starts the next one: reconf_fail, a self-test fail, or ATTEMPT_TO wait cycles without an answer. After a timeout, the next request follows the previous one by exactly ATTEMPT_TO+1 cycles.
- R8: degraded rises and stays high if a tile is retired when no spare is available. This covers both a failed full reconfiguration and a count above RETIRE_LIMIT.
- R9: A count above RETIRE_LIMIT retires the tile. A retired tile stays isolated and in reset and is never activated again.
- R10: Disagreements from spare, repairing or retired tiles are ignored.
- R11: A count at or above SWAP_AT with no spare available gives only a resync.
- R12: An active tile whose strobe stays low for WDOG_WIN consecutive edges is treated as disagreeing on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disagree | input | N_TILES | Per-tile disagreement flag |
| chk_strobe | input | N_TILES | Per-tile checkpoint strobe |
| reconf_done | input | 1 | Reconfiguration completed |
| reconf_fail | input | 1 | Reconfiguration failed |
| selftest_done | input | 1 | Self-test result valid |
| selftest_pass | input | 1 | Self-test outcome, 1 means pass |
| resync_req | output | N_TILES | One-cycle state-update request per tile |
| spare_act | output | N_TILES | One-cycle spare activation command |
| tile_reset | output | N_TILES | Holds a tile in reset |
| tile_isolate | output | N_TILES | Disconnects a tile from the interconnect |
| part_reconf_req | output | 1 | Partial reconfiguration request |
| full_reconf_req | output | 1 | Full reconfiguration request |
| cfg_variant | output | $clog2(N_VARIANTS+1) | Attempt index for the current request |
| selftest_req | output | 1 | Self-test request |
| degraded | output | 1 | Spare pool exhausted |

## Verification
Two things can compete in one cycle. The first is two tiles that disagree on the same edge. The second is a new fault that arrives while a repair sequence holds the controller. The bench raises two disagreement flags together and expects two resync pulses on consecutive cycles, lowest index first. It also injects a disagreement during a reconfiguration wait. It then checks that nothing is issued for that tile until the repair ends, and that the held fault is served on the very next edge.

// File: rtl/ths_pkg.sv
package ths_pkg;
    typedef enum logic [1:0] {
        H_ACTIVE  = 2'd0,
        H_SPARE   = 2'd1,
        H_REPAIR  = 2'd2,
        H_RETIRED = 2'd3
    } health_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_REQ   = 3'd1,
        S_RWAIT = 3'd2,
        S_TEST  = 3'd3,
        S_TWAIT = 3'd4
    } phase_t;
endpackage

// File: rtl/ths_watchdog.sv
module ths_watchdog #(
    parameter int WIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    output logic bite
);
    localparam int W = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [W-1:0] LAST = W'(WIN - 1);

    logic [W-1:0] cnt;

    assign bite = en && !strobe && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || strobe || bite) cnt <= '0;
        else                                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ths_timer.sv
module ths_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tile_health_supervisor.sv
module tile_health_supervisor
    import ths_pkg::*;
#(
    parameter int N_TILES      = 4,
    parameter int N_SPARE      = 1,
    parameter int SWAP_AT      = 2,
    parameter int RETIRE_LIMIT = 3,
    parameter int N_VARIANTS   = 2,
    parameter int ATTEMPT_TO   = 16,
    parameter int WDOG_WIN     = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_TILES-1:0]                disagree,
    input  logic [N_TILES-1:0]                chk_strobe,
    input  logic                              reconf_done,
    input  logic                              reconf_fail,
    input  logic                              selftest_done,
    input  logic                              selftest_pass,
    output logic [N_TILES-1:0]                resync_req,
    output logic [N_TILES-1:0]                spare_act,
    output logic [N_TILES-1:0]                tile_reset,
    output logic [N_TILES-1:0]                tile_isolate,
    output logic                              part_reconf_req,
    output logic                              full_reconf_req,
    output logic [$clog2(N_VARIANTS+1)-1:0]   cfg_variant,
    output logic                              selftest_req,
    output logic                              degraded
);
    localparam int CNT_W = $clog2(RETIRE_LIMIT + 2);
    localparam int IDX_W = (N_TILES > 2) ? $clog2(N_TILES) : 1;
    localparam int ATT_W = $clog2(N_VARIANTS + 1);
    localparam logic [CNT_W-1:0] SWAP_C   = CNT_W'(SWAP_AT);
    localparam logic [CNT_W-1:0] RETIRE_C = CNT_W'(RETIRE_LIMIT);
    localparam logic [ATT_W-1:0] LAST_ATT = ATT_W'(N_VARIANTS);

    health_t            health [N_TILES];
    logic [CNT_W-1:0]   fcnt   [N_TILES];
    logic [N_TILES-1:0] pend_q, pend_eff, wd_bite, active_v, spare_v, rep_v;
    logic [N_TILES-1:0] resync_q, spare_q;
    phase_t             phase, phase_nx;
    logic [IDX_W-1:0]   rep_idx, sel, spare_sel;
    logic [ATT_W-1:0]   att;
    logic               has_pend, has_spare, swap_go, tmo, att_fail, last_att, degraded_q;
    logic [CNT_W-1:0]   new_cnt;

    // per-tile status vectors and watchdogs
    for (genvar g = 0; g < N_TILES; g++) begin : g_tile
        assign active_v[g]     = (health[g] == H_ACTIVE);
        assign spare_v[g]      = (health[g] == H_SPARE);
        assign rep_v[g]        = (health[g] == H_REPAIR);
        assign tile_isolate[g] = rep_v[g] || (health[g] == H_RETIRED);
        assign tile_reset[g]   = (health[g] == H_RETIRED) ||
                                 (rep_v[g] && phase != S_TEST && phase != S_TWAIT);

        ths_watchdog #(.WIN(WDOG_WIN)) u_wd (
            .clk(clk), .rst_n(rst_n), .en(active_v[g]),
            .strobe(chk_strobe[g]), .bite(wd_bite[g])
        );

        AST_RETIRED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
            health[g] == H_RETIRED |=> health[g] == H_RETIRED); // R9
        AST_RESET_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
            tile_reset[g] |-> tile_isolate[g]); // R5
    end

    ths_timer #(.LIMIT(ATTEMPT_TO)) u_tmo (
        .clk(clk), .rst_n(rst_n),
        .run(phase == S_RWAIT || phase == S_TWAIT), .expired(tmo)
    );

    assign pend_eff = (pend_q | disagree | wd_bite) & active_v;
    assign new_cnt  = fcnt[sel] + 1'b1;
    assign swap_go  = has_spare && (new_cnt >= SWAP_C) && (new_cnt <= RETIRE_C);
    assign last_att = (att == LAST_ATT);
    assign att_fail = (phase == S_RWAIT && (reconf_fail || tmo)) ||
                      (phase == S_TWAIT && ((selftest_done && !selftest_pass) || tmo));

    // lowest-index pending fault and lowest-index spare
    always_comb begin
        has_pend  = 1'b0;
        sel       = '0;
        has_spare = 1'b0;
        spare_sel = '0;
        for (int i = N_TILES - 1; i >= 0; i--) begin
            if (pend_eff[i]) begin
                has_pend = 1'b1;
                sel      = IDX_W'(i);
            end
            if (spare_v[i]) begin
                has_spare = 1'b1;
                spare_sel = IDX_W'(i);
            end
        end
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            S_IDLE:  if (has_pend && swap_go) phase_nx = S_REQ;
            S_REQ:   phase_nx = S_RWAIT;
            S_RWAIT: if (att_fail)         phase_nx = last_att ? S_IDLE : S_REQ;
                     else if (reconf_done) phase_nx = S_TEST;
            S_TEST:  phase_nx = S_TWAIT;
            S_TWAIT: if (att_fail)           phase_nx = last_att ? S_IDLE : S_REQ;
                     else if (selftest_done) phase_nx = S_IDLE;
            default: phase_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= S_IDLE;
            pend_q     <= '0;
            resync_q   <= '0;
            spare_q    <= '0;
            att        <= '0;
            rep_idx    <= '0;
            degraded_q <= 1'b0;
            for (int i = 0; i < N_TILES; i++) begin
                health[i] <= (i < N_TILES - N_SPARE) ? H_ACTIVE : H_SPARE;
                fcnt[i]   <= '0;
            end
        end else begin
            phase    <= phase_nx;
            pend_q   <= pend_eff;
            resync_q <= '0;
            spare_q  <= '0;
            if (phase == S_IDLE && has_pend) begin
                pend_q[sel] <= 1'b0;
                fcnt[sel]   <= new_cnt;
                if (new_cnt > RETIRE_C) begin
                    health[sel] <= H_RETIRED;
                    if (has_spare) begin
                        health[spare_sel]  <= H_ACTIVE;
                        spare_q[spare_sel] <= 1'b1;
                    end else begin
                        degraded_q <= 1'b1;
                    end
                end else if (swap_go) begin
                    health[sel]        <= H_REPAIR;
                    health[spare_sel]  <= H_ACTIVE;
                    spare_q[spare_sel] <= 1'b1;
                    rep_idx            <= sel;
                    att                <= '0;
                end else begin
                    resync_q[sel] <= 1'b1;
                end
            end
            if (att_fail) begin
                if (last_att) begin
                    health[rep_idx] <= H_RETIRED;
                    if (!has_spare) degraded_q <= 1'b1;
                end else begin
                    att <= att + 1'b1;
                end
            end else if (phase == S_TWAIT && selftest_done) begin
                health[rep_idx] <= H_SPARE;
            end
        end
    end

    // outputs
    always_comb begin
        resync_req      = resync_q;
        spare_act       = spare_q;
        part_reconf_req = (phase == S_REQ) && !last_att;
        full_reconf_req = (phase == S_REQ) && last_att;
        cfg_variant     = att;
        selftest_req    = (phase == S_TEST);
        degraded        = degraded_q;
    end

    AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resync_req)); // R3
    AST_ONE_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rep_v) <= 1); // R4
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(part_reconf_req && full_reconf_req)); // R6
    AST_DEGRADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        degraded |=> degraded); // R8
    AST_SPARE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spare_act)); // R5
endmodule

// File: tb/test_tile_health_supervisor.sv
module test_tile_health_supervisor;
    localparam int N   = 4;
    localparam int TO  = 16;
    localparam int WIN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] disagree = '0;
    logic [N-1:0] chk_strobe = '1;
    logic reconf_done = 1'b0, reconf_fail = 1'b0, selftest_done = 1'b0, selftest_pass = 1'b0;
    logic [N-1:0] resync_req, spare_act, tile_reset, tile_isolate;
    logic part_reconf_req, full_reconf_req, selftest_req, degraded;
    logic [1:0] cfg_variant;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tile_health_supervisor #(
        .N_TILES(N), .N_SPARE(1), .SWAP_AT(2), .RETIRE_LIMIT(3),
        .N_VARIANTS(2), .ATTEMPT_TO(TO), .WDOG_WIN(WIN)
    ) i_tile_health_supervisor (
        .clk(clk), .rst_n(rst_n), .disagree(disagree), .chk_strobe(chk_strobe),
        .reconf_done(reconf_done), .reconf_fail(reconf_fail),
        .selftest_done(selftest_done), .selftest_pass(selftest_pass),
        .resync_req(resync_req), .spare_act(spare_act), .tile_reset(tile_reset),
        .tile_isolate(tile_isolate), .part_reconf_req(part_reconf_req),
        .full_reconf_req(full_reconf_req), .cfg_variant(cfg_variant),
        .selftest_req(selftest_req), .degraded(degraded)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk) disagree = m;
        @(posedge clk); #1;
        disagree = '0;
    endtask

    task automatic reconf_answer(input bit fail);
        @(negedge clk) begin reconf_done = ~fail; reconf_fail = fail; end
        @(posedge clk); #1;
        reconf_done = 1'b0; reconf_fail = 1'b0;
    endtask

    task automatic test_answer(input bit pass);
        @(negedge clk) begin selftest_done = 1'b1; selftest_pass = pass; end
        @(posedge clk); #1;
        selftest_done = 1'b0; selftest_pass = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit quiet;
        int n;
        bit seen;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step();
        // R1 reset state
        check({resync_req, spare_act, tile_reset, tile_isolate} == '0 && !part_reconf_req &&
              !full_reconf_req && !selftest_req && !degraded, "R1 reset outputs",
              {resync_req, tile_isolate}, 0);

        // R2 passive while all agree
        quiet = 1'b1;
        for (int c = 0; c < 30; c++) begin
            step();
            if (resync_req != 0 || spare_act != 0 || part_reconf_req || full_reconf_req) quiet = 1'b0;
        end
        check(quiet, "R2 passive", quiet, 1);

        // R4 simultaneous faults on tiles 1 and 2: lowest first
        pulse(4'b0110);
        check(resync_req == 4'b0010, "R4 first served", resync_req, 4'b0010);
        step();
        check(resync_req == 4'b0100, "R4 second served", resync_req, 4'b0100);
        step();
        check(resync_req == 4'b0000, "R3 pulse one cycle", resync_req, 0);

        // R3 single fault sweep on tile 0
        pulse(4'b0001);
        check(resync_req == 4'b0001, "R3 resync tile0", resync_req, 1);

        // R10 spare tile 3 disagreement ignored
        pulse(4'b1000);
        quiet = (resync_req == 0 && spare_act == 0);
        for (int c = 0; c < 5; c++) begin
            step();
            if (resync_req != 0 || part_reconf_req || spare_act != 0) quiet = 1'b0;
        end
        check(quiet, "R10 spare ignored", quiet, 1);

        // R5 swap tile0 (count 2) with spare 3
        pulse(4'b0001);
        check(spare_act == 4'b1000, "R5 spare_act", spare_act, 4'b1000);
        check(tile_isolate == 4'b0001 && tile_reset == 4'b0001, "R5 isolate+reset",
              {tile_isolate, tile_reset}, 8'h11);
        check(part_reconf_req && cfg_variant == 0, "R6 variant0 request", cfg_variant, 0);
        step();
        reconf_answer(1'b1);
        check(part_reconf_req && cfg_variant == 1, "R7 fail to variant1", cfg_variant, 1);
        // R4 fault on tile 2 during repair is held; R7 timeout to full
        @(negedge clk) disagree = 4'b0100;
        n = 0; seen = 1'b0;
        while (!full_reconf_req && n < 100) begin
            @(posedge clk); #1;
            disagree = '0;
            n++;
            if (resync_req != 0 || spare_act != 0) seen = 1'b1;
        end
        check(n == TO + 1, "R7 timeout spacing", n, TO + 1);
        check(!seen, "R4 held during repair", seen, 0);
        check(cfg_variant == 2, "R6 full attempt index", cfg_variant, 2);
        step();
        reconf_answer(1'b0);
        check(selftest_req && tile_reset[0] == 1'b0 && tile_isolate[0] == 1'b1,
              "R6 selftest out of reset", {tile_reset, tile_isolate}, 8'h01);
        step();
        test_answer(1'b1);
        check(tile_isolate[0] == 1'b0 && tile_reset[0] == 1'b0, "R6 pass returns spare",
              tile_isolate, 0);
        step();
        check(spare_act == 4'b0001 && tile_isolate == 4'b0100, "R4 held fault served",
              {spare_act, tile_isolate}, 8'h14);

        // tile 2 repair: self-test fail then pass on variant1
        check(part_reconf_req && cfg_variant == 0, "R6 tile2 variant0", cfg_variant, 0);
        step();
        reconf_answer(1'b0);
        step();
        test_answer(1'b0);
        check(part_reconf_req && cfg_variant == 1, "R7 selftest fail advances", cfg_variant, 1);
        step();
        reconf_answer(1'b0);
        step();
        test_answer(1'b1);
        check(tile_isolate == 4'b0000, "R6 tile2 back", tile_isolate, 0);

        // tile 1 (count 2) swap with tile 2, all attempts fail -> retire, degraded
        pulse(4'b0010);
        check(spare_act == 4'b0100, "R5 lowest spare tile2", spare_act, 4'b0100);
        step();
        reconf_answer(1'b1);
        step();
        reconf_answer(1'b1);
        check(full_reconf_req, "R6 full request", full_reconf_req, 1);
        step();
        reconf_answer(1'b1);
        check(degraded && tile_isolate == 4'b0010 && tile_reset == 4'b0010,
              "R8 degraded after full fail", {degraded, tile_isolate}, 8'h12);

        // R11 tile0 count 3, no spare: resync only
        pulse(4'b0001);
        check(resync_req == 4'b0001 && spare_act == 0 && tile_isolate == 4'b0010,
              "R11 resync only", resync_req, 1);
        step();
        check(!part_reconf_req, "R11 no repair", part_reconf_req, 0);

        // R9 tile0 count 4 > limit: retired
        pulse(4'b0001);
        check(resync_req == 0 && spare_act == 0 && tile_isolate == 4'b0011 && degraded,
              "R9 retire", tile_isolate, 4'b0011);
        pulse(4'b0011);
        quiet = (resync_req == 0);
        for (int c = 0; c < 4; c++) begin
            step();
            if (resync_req != 0 || part_reconf_req || spare_act != 0) quiet = 1'b0;
        end
        check(quiet && tile_isolate == 4'b0011 && tile_reset == 4'b0011,
              "R10 retired ignored", tile_isolate, 4'b0011);

        // R12 watchdog on tile 3
        @(negedge clk) chk_strobe = 4'b0111;
        n = 0;
        while (resync_req != 4'b1000 && n < 200) begin
            @(posedge clk); #1;
            n++;
        end
        check(n == WIN, "R12 watchdog window", n, WIN);
        chk_strobe = '1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule